// File: doc/BRIEF.md
# Operand Shift and Rotate Unit with Condition Flags

This block is a purely combinational shifter for byte, word and long operands. One cycle's worth of logic takes an operand, a size select, an operation select, a six-bit count and the incoming extend flag, and produces the shifted or rotated result together with new extend (X), negative (N), zero (Z), overflow (V) and carry (C) flags. It sits in an execution stage next to the adder and logic unit. The surrounding pipeline registers its outputs and writes the flags back.

Eight operations are supported:
- arithmetic shifts left and right;
- logical shifts left and right;
- plain rotates left and right;
- rotates left and right through the extend bit, where X and the operand together form a ring one bit wider than the operand.

Counts of zero and counts at or beyond the operand width are defined cases, not errors. The left arithmetic shift reports a signed overflow if any bit that passes through the sign position differs from the original sign.

Top module: `shr_unit`

## Requirements
- R1: The count is used as given, from 0 to 63. A count of zero returns the operand unchanged and keeps X. C is cleared for every operation except the two rotates through extend.
- R2: For the four shifts, C and X both take the last bit shifted out. When the count is at or above the operand width, left and logical-right shifts give zero, and the arithmetic right shift fills the result and C with the sign bit.
- R3: For arithmetic left shift with count k > 0, V is set when the top min(k+1, width) bits of the original operand are not all equal. A count of zero gives V = 0.
- R4: V is 0 for every operation other than arithmetic left shift.
- R5: Plain rotates use the count modulo the operand width and leave X unchanged. For a non-zero count, C is the new LSB after a rotate left and the new MSB after a rotate right.
- R6: Rotates through extend treat {X, operand} as a ring of width+1 bits and use the count modulo width+1. The bit left in the extend position drives both X and C, so a count of zero gives C = X_in.
- R7: N equals the top bit of the sized result, and Z is 1 exactly when the sized result is zero.
- R8: The operation codes are ASL=0, ASR=1, LSL=2, LSR=3, ROL=4, ROR=5, ROXL=6 and ROXR=7. The size codes are 0 for byte, 1 for word and 2 for long; code 3 behaves as long. Result bits above the selected width are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Operand; only the low bits of the selected width are used |
| size_i | input | 2 | Operand width select |
| op_i | input | 3 | Operation select |
| count_i | input | 6 | Shift or rotate count |
| x_i | input | 1 | Incoming extend flag |
| result_o | output | 32 | Sized result, zero-extended |
| x_o | output | 1 | New extend flag |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| v_o | output | 1 | New overflow flag |
| c_o | output | 1 | New carry flag |

## Verification
The block holds no state. Any fault in a lane, a modulo reduction or the flag steering shows up at the ports within the same evaluation as the input vector that exercises it. The risky spots are the count boundaries: 0, width-1, width, width+1 and 63. At those counts, a wrong modulo or a stray shift amount corrupts C, X or V even when the result looks right. The bench therefore sweeps every count at every size for all eight operations and compares all six outputs. Directed vectors pin down overflow detection, the extend ring and the clearing of the upper result bits.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_ASL  = 3'd0,
    OP_ASR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_ROXL = 3'd6,
    OP_ROXR = 3'd7
  } shr_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } shr_size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } shr_flags_t;

  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned MAX_W     = 32;
  localparam int unsigned CNT_W     = 6;
endpackage

// File: rtl/shr_shift_core.sv
module shr_shift_core #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       sel_i,   // 00 asl, 01 asr, 10 lsl, 11 lsr
  output logic [W-1:0]     res_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned SH_W = CNT_W;

  logic signed [W-1:0] sval;
  logic [SH_W-1:0]     cnt_m1;
  logic [SH_W-1:0]     asl_sh;
  logic [W-1:0]        left_pre, right_pre;
  logic signed [W-1:0] arith_pre, sign_run;
  logic                cnt_zero;

  assign sval     = val_i;
  assign cnt_m1   = cnt_i - SH_W'(1);
  assign cnt_zero = (cnt_i == '0);

  // Shift by count-1: the bit that leaves on the final step sits at the edge.
  assign left_pre  = val_i << cnt_m1;
  assign right_pre = val_i >> cnt_m1;
  assign arith_pre = sval >>> cnt_m1;

  // Top count+1 bits, sign-spread, compare all-equal.
  assign asl_sh   = (int'(cnt_i) >= int'(W)) ? '0 : SH_W'(W - 1) - cnt_i;
  assign sign_run = sval >>> asl_sh;

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    unique case (sel_i)
      2'b00, 2'b10: begin
        res_o   = val_i << cnt_i;
        carry_o = !cnt_zero && left_pre[W-1];
      end
      2'b01: begin
        res_o   = W'(sval >>> cnt_i);
        carry_o = !cnt_zero && arith_pre[0];
      end
      default: begin
        res_o   = val_i >> cnt_i;
        carry_o = !cnt_zero && right_pre[0];
      end
    endcase
  end

  assign ovf_o = !cnt_zero && !((&sign_run) || !(|sign_run));

  // R2
  always_comb begin
    asr_fill_chk: assert (!(sel_i == 2'b01 && int'(cnt_i) >= int'(W)) ||
                          res_o == {W{val_i[W-1]}})
      else $error("asr fill wrong");
  end
endmodule

// File: rtl/shr_rot_core.sv
module shr_rot_core #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             x_i,
  input  logic [1:0]       sel_i,   // 00 rol, 01 ror, 10 roxl, 11 roxr
  output logic [W-1:0]     res_o,
  output logic             carry_o,
  output logic             ring_o
);
  localparam int unsigned AMT_W = CNT_W + 1;
  localparam int unsigned RING  = W + 1;

  logic [AMT_W-1:0] k_mod, kx_mod;
  logic [W:0]       ring_in, ring_l, ring_r;
  logic [W-1:0]     rot_l, rot_r;

  assign k_mod   = AMT_W'(cnt_i % CNT_W'(W));
  assign kx_mod  = AMT_W'(cnt_i % CNT_W'(RING));
  assign ring_in = {x_i, val_i};

  assign rot_l  = (val_i << k_mod) | (val_i >> (AMT_W'(W) - k_mod));
  assign rot_r  = (val_i >> k_mod) | (val_i << (AMT_W'(W) - k_mod));
  assign ring_l = (ring_in << kx_mod) | (ring_in >> (AMT_W'(RING) - kx_mod));
  assign ring_r = (ring_in >> kx_mod) | (ring_in << (AMT_W'(RING) - kx_mod));

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    ring_o  = x_i;
    unique case (sel_i)
      2'b00: begin res_o = rot_l; carry_o = rot_l[0]; end
      2'b01: begin res_o = rot_r; carry_o = rot_r[W-1]; end
      2'b10: begin res_o = ring_l[W-1:0]; ring_o = ring_l[W]; carry_o = ring_l[W]; end
      default: begin res_o = ring_r[W-1:0]; ring_o = ring_r[W]; carry_o = ring_r[W]; end
    endcase
  end
endmodule

// File: rtl/shr_lane.sv
module shr_lane
  import shr_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 6,
  parameter int unsigned OUT_W = 32
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       op_i,
  input  logic             x_i,
  output logic [OUT_W-1:0] res_o,
  output shr_flags_t       flags_o
);
  logic [W-1:0] sh_res, rt_res, sel_res;
  logic         sh_c, sh_v, rt_c, rt_ring;
  logic         is_rot, is_rox, cnt_zero;

  shr_shift_core #(.W(W), .CNT_W(CNT_W)) u_shift (
    .val_i(val_i), .cnt_i(cnt_i), .sel_i(op_i[1:0]),
    .res_o(sh_res), .carry_o(sh_c), .ovf_o(sh_v)
  );

  shr_rot_core #(.W(W), .CNT_W(CNT_W)) u_rot (
    .val_i(val_i), .cnt_i(cnt_i), .x_i(x_i), .sel_i(op_i[1:0]),
    .res_o(rt_res), .carry_o(rt_c), .ring_o(rt_ring)
  );

  assign is_rot   = op_i[2];
  assign is_rox   = op_i[2] & op_i[1];
  assign cnt_zero = (cnt_i == '0);
  assign sel_res  = is_rot ? rt_res : sh_res;
  assign res_o    = OUT_W'(sel_res);

  always_comb begin
    flags_o.n = sel_res[W-1];
    flags_o.z = (sel_res == '0);
    flags_o.v = (op_i == OP_ASL) && sh_v;
    if (is_rox) begin
      flags_o.x = rt_ring;
      flags_o.c = rt_c;
    end else if (is_rot) begin
      flags_o.x = x_i;
      flags_o.c = !cnt_zero && rt_c;
    end else begin
      flags_o.x = cnt_zero ? x_i : sh_c;
      flags_o.c = sh_c;
    end
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
(
  input  logic [31:0] operand_i,
  input  logic [1:0]  size_i,
  input  logic [2:0]  op_i,
  input  logic [5:0]  count_i,
  input  logic        x_i,
  output logic [31:0] result_o,
  output logic        x_o,
  output logic        n_o,
  output logic        z_o,
  output logic        v_o,
  output logic        c_o
);
  logic [MAX_W-1:0] lane_res   [NUM_LANES];
  shr_flags_t       lane_flags [NUM_LANES];
  logic [1:0]       lane_sel;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = 8 << g;
    shr_lane #(.W(LW), .CNT_W(CNT_W), .OUT_W(MAX_W)) u_lane (
      .val_i  (operand_i[LW-1:0]),
      .cnt_i  (count_i),
      .op_i   (op_i),
      .x_i    (x_i),
      .res_o  (lane_res[g]),
      .flags_o(lane_flags[g])
    );
  end

  // Reserved size code falls back to long.
  assign lane_sel = (size_i == SZ_RSVD) ? 2'(SZ_LONG) : size_i;

  assign result_o = lane_res[lane_sel];
  assign x_o      = lane_flags[lane_sel].x;
  assign n_o      = lane_flags[lane_sel].n;
  assign z_o      = lane_flags[lane_sel].z;
  assign v_o      = lane_flags[lane_sel].v;
  assign c_o      = lane_flags[lane_sel].c;

  always_comb begin
    // R4
    v_only_asl_chk: assert (op_i == OP_ASL || !v_o) else $error("V outside ASL");
    // R5
    rot_x_keep_chk: assert (!(op_i == OP_ROL || op_i == OP_ROR) || x_o == x_i)
      else $error("rotate touched X");
    // R1
    zero_cnt_chk: assert (!(count_i == 6'd0 && !op_i[1] | !op_i[2]) ||
                          (!c_o && x_o == x_i))
      else $error("zero count flags");
    // R8
    upper_zero_chk: assert (!(size_i == SZ_BYTE) || result_o[31:8] == '0)
      else $error("upper bits set");
    // R6
    rox_xc_chk: assert (!(op_i[2] && op_i[1]) || x_o == c_o)
      else $error("rox X/C differ");
  end
endmodule

// File: tb/shr_unit_bench.sv
module shr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand;
  logic [1:0]  size;
  logic [2:0]  op;
  logic [5:0]  count;
  logic        x_in;
  logic [31:0] result;
  logic        x_out, n_out, z_out, v_out, c_out;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shr_unit u_shr_unit (
    .operand_i(operand), .size_i(size), .op_i(op), .count_i(count), .x_i(x_in),
    .result_o(result), .x_o(x_out), .n_o(n_out), .z_o(z_out), .v_o(v_out), .c_o(c_out)
  );

  // Stepwise model built from the requirements.
  function automatic void ref_model(input logic [31:0] opnd, input logic [1:0] sz,
                                    input logic [2:0] o, input logic [5:0] cnt,
                                    input logic xi, output logic [37:0] exp);
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] v = opnd & mask;
    logic x = xi, c = 1'b0, ov = 1'b0, msb, lsb, out = 1'b0;
    int top;
    for (int i = 0; i < int'(cnt); i++) begin
      msb = v[w-1];
      lsb = v[0];
      case (o)
        3'd0, 3'd2: begin out = msb; v = (v << 1) & mask; end
        3'd1: begin out = lsb; v = (v >> 1) | ({31'd0, msb} << (w-1)); end
        3'd3: begin out = lsb; v = v >> 1; end
        3'd4: v = ((v << 1) | {31'd0, msb}) & mask;
        3'd5: v = (v >> 1) | ({31'd0, lsb} << (w-1));
        3'd6: begin v = ((v << 1) | {31'd0, x}) & mask; x = msb; end
        default: begin v = (v >> 1) | ({31'd0, x} << (w-1)); x = lsb; end
      endcase
    end
    if (o == 3'd6 || o == 3'd7) c = x;
    else if (cnt == 6'd0) c = 1'b0;
    else if (o == 3'd4) c = v[0];
    else if (o == 3'd5) c = v[w-1];
    else begin c = out; x = out; end
    if (o == 3'd0 && cnt != 6'd0) begin
      top = (int'(cnt) + 1 > w) ? w : int'(cnt) + 1;
      for (int b = w - top; b < w; b++)
        if (opnd[b] != opnd[w-1]) ov = 1'b1;
    end
    exp = {v, x, v[w-1], (v == 32'd0), ov, c, 1'b0};
  endfunction

  task automatic apply(input logic [31:0] opnd, input logic [1:0] sz, input logic [2:0] o,
                       input logic [5:0] cnt, input logic xi, input string tag);
    logic [37:0] exp, act;
    operand = opnd; size = sz; op = o; count = cnt; x_in = xi;
    #1;
    ref_model(opnd, sz, o, cnt, xi, exp);
    act = {result, x_out, n_out, z_out, v_out, c_out, 1'b0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d sz=%0d cnt=%0d opnd=%h x=%b: actual res=%h xnzvc=%b expected res=%h xnzvc=%b",
               tag, o, sz, cnt, opnd, xi, act[37:6], act[5:1], exp[37:6], exp[5:1]);
    end
    #1;
  endtask

  task automatic expect_bits(input logic [31:0] a, input logic [31:0] e, input string tag);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic t_reset_state();
    apply(32'd0, 2'd2, 3'd0, 6'd0, 1'b0, "R7 reset");
    expect_bits(result, 32'd0, "R7 reset result");
    expect_bits({31'd0, z_out}, 32'd1, "R7 reset zero flag");
  endtask

  task automatic t_zero_count();
    for (int o = 0; o < 8; o++) begin
      apply(32'h8000_00A5, 2'd0, 3'(o), 6'd0, 1'b1, "R1 zero count byte");
      apply(32'h1234_8000, 2'd1, 3'(o), 6'd0, 1'b1, "R1 zero count word");
      apply(32'hF000_0001, 2'd2, 3'(o), 6'd0, 1'b0, "R1 zero count long");
    end
    apply(32'h0000_0081, 2'd0, 3'd1, 6'd0, 1'b1, "R1 asr zero");
    expect_bits({31'd0, c_out}, 32'd0, "R1 C cleared");
  endtask

  task automatic t_large_counts();
    apply(32'h0000_0080, 2'd0, 3'd1, 6'd20, 1'b0, "R2 asr byte beyond");
    expect_bits(result, 32'h0000_00FF, "R2 asr sign fill");
    apply(32'h0000_FFFF, 2'd1, 3'd2, 6'd16, 1'b0, "R2 lsl word at width");
    apply(32'h0000_8001, 2'd1, 3'd3, 6'd17, 1'b1, "R2 lsr word past width");
    apply(32'hFFFF_FFFF, 2'd2, 3'd0, 6'd63, 1'b0, "R2 asl long max");
    expect_bits(result, 32'd0, "R2 asl long max zero");
  endtask

  task automatic t_asl_overflow();
    apply(32'h0000_0040, 2'd0, 3'd0, 6'd1, 1'b0, "R3 sign change");
    expect_bits({31'd0, v_out}, 32'd1, "R3 V set");
    apply(32'h0000_0020, 2'd0, 3'd0, 6'd1, 1'b0, "R3 no change");
    apply(32'h0000_00FF, 2'd0, 3'd0, 6'd8, 1'b0, "R3 all ones");
    expect_bits({31'd0, v_out}, 32'd0, "R3 all ones V clear");
    apply(32'h0000_0001, 2'd0, 3'd0, 6'd9, 1'b0, "R3 beyond width");
    apply(32'hC000_0000, 2'd2, 3'd0, 6'd1, 1'b0, "R3 long two ones");
    apply(32'hC000_0000, 2'd2, 3'd0, 6'd2, 1'b0, "R3 long three bits");
    apply(32'h0000_0040, 2'd0, 3'd2, 6'd1, 1'b0, "R4 lsl no V");
  endtask

  task automatic t_rotates();
    apply(32'h0000_0081, 2'd0, 3'd4, 6'd8, 1'b1, "R5 rol full turn");
    apply(32'h0000_0081, 2'd0, 3'd5, 6'd9, 1'b0, "R5 ror mod width");
    apply(32'h0000_8000, 2'd1, 3'd6, 6'd17, 1'b0, "R6 roxl full ring");
    expect_bits(result, 32'h0000_8000, "R6 ring identity");
    apply(32'h0000_0001, 2'd0, 3'd7, 6'd1, 1'b0, "R6 roxr into X");
    expect_bits({31'd0, x_out}, 32'd1, "R6 X from ring");
    apply(32'h0000_0055, 2'd0, 3'd6, 6'd0, 1'b1, "R6 zero count C=X");
  endtask

  task automatic t_sizes();
    apply(32'hFFFF_FFFF, 2'd0, 3'd3, 6'd1, 1'b0, "R8 byte upper zero");
    expect_bits(result, 32'h0000_007F, "R8 byte lsr");
    apply(32'hFFFF_FFFF, 2'd1, 3'd4, 6'd3, 1'b0, "R8 word upper zero");
    apply(32'h8000_0001, 2'd3, 3'd5, 6'd1, 1'b0, "R8 reserved as long");
    expect_bits(result, 32'hC000_0000, "R8 reserved long ror");
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 8; o++)
        for (int c = 0; c < 64; c++)
          for (int r = 0; r < 2; r++)
            apply($urandom, 2'(s), 3'(o), 6'(c), 1'($urandom), "R1 R2 R3 R4 R5 R6 R7 sweep");
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    operand = '0; size = '0; op = '0; count = '0; x_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_zero_count();
    t_large_counts();
    t_asl_overflow();
    t_rotates();
    t_sizes();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule